// File: doc/BRIEF.md
# Receive Queue Steering Table

This block steers received traffic across a small set of receive queues. Each packet arrives with a 32-bit hash. The low seven bits of that hash select one of 128 table entries, and each entry names a 3-bit receive queue. A lookup port accepts a hash together with a valid strobe. One clock later it returns the chosen queue with its own valid strobe.

Software reaches the table through a flat 32-bit word interface. Four entries are packed into each word, one per byte lane. A byte-enable lets a write replace any subset of the four entries in a word. A fill engine can load a default spread: entry i gets queue (i mod Q), and one word is committed per cycle.

The block has a "written" flag that records software ownership of the table. While the flag is set, the default fill is refused, so values chosen by software are never overwritten. A stop pulse or a reset clears the flag.

Top module: `rss_queue_map`

## Requirements
- R1: On a cycle with `hash_valid` high, the next cycle raises `q_valid` and drives `q_index` with the entry selected by `hash[6:0]`. The upper hash bits have no effect. `q_valid` is low in the cycle after a cycle without `hash_valid`.
- R2: Entry n is held in word n>>2 at bits 8*(n&3)+2 down to 8*(n&3). `reg_rdata` shows the word selected by `reg_addr` in the same cycle, and bits 7:3 of every byte read as zero.
- R3: A register write replaces only the entries whose `reg_be` bit is set, using the low 3 bits of the matching data byte. The other entries of the word keep their values.
- R4: A register write and a lookup of the same entry in the same cycle return the entry's value from before the write.
- R5: A `fill_start` pulse with the written flag clear and no fill running makes `fill_busy` high for exactly 32 cycles. After the fill, entry i holds i mod Q.
- R6: A `fill_qcount` of 0 fills as Q = 1, so every entry is 0. A count above 8 fills as Q = 8.
- R7: A lookup presented while `fill_busy` is high returns queue 0 with `q_valid` high.
- R8: A register write with at least one byte-enable set, accepted while no fill is running, sets `sw_written`. While `sw_written` is high, `fill_start` is ignored: `fill_busy` stays low and the table is unchanged.
- R9: Reset clears every entry to 0, clears `sw_written` and leaves `fill_busy` and `q_valid` low. A `stop_clr` pulse clears `sw_written` without changing the table.
- R10: Register writes presented while `fill_busy` is high are dropped: they change neither the table nor `sw_written`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| stop_clr | input | 1 | Pulse that clears the software-written flag |
| fill_start | input | 1 | Pulse that requests the default round-robin fill |
| fill_qcount | input | 4 | Queue count Q used by the default fill |
| fill_busy | output | 1 | High while the fill engine writes the table |
| sw_written | output | 1 | Table has been written by software since the last clear |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 5 | Word address (entries 4*addr to 4*addr+3) |
| reg_be | input | 4 | Byte enable, one bit per entry of the word |
| reg_wdata | input | 32 | Write data, one entry per byte |
| reg_rdata | output | 32 | Read data for the word at `reg_addr` |
| hash_valid | input | 1 | Lookup request strobe |
| hash | input | 32 | Receive hash |
| q_valid | output | 1 | Lookup result strobe |
| q_index | output | 3 | Selected receive queue |

## Verification
Lookups are issued with hashes whose upper bits vary while the low seven bits sweep across entries. This separates correct index extraction from use of the wrong hash bits. The fill is run with queue counts of 5, 3, 0 and 12. Five does not divide 128, so it exposes an off-by-one in the round-robin wrap, while 0 and 12 exercise the two clamps. Masked writes with sparse byte-enables, and a write that collides with a lookup of the same entry, separate per-lane storage from whole-word storage and old-value reads from new-value reads. Fill requests made while software owns the table, and writes made during a fill, show whether the ownership rules hold.

// File: rtl/rssq_pkg.sv
package rssq_pkg;
   // one table entry per byte lane of a register word
   localparam int unsigned LANE_W = 8;
   localparam int unsigned LANES  = 4;

   typedef enum logic {
      WSRC_SW   = 1'b0,
      WSRC_FILL = 1'b1
   } wsrc_e;
endpackage

// File: rtl/rssq_table.sv
module rssq_table
   import rssq_pkg::*;
#(
   parameter int unsigned ENTRIES = 128,
   parameter int unsigned QIDX_W  = 3,
   localparam int unsigned IDX_W  = $clog2(ENTRIES),
   localparam int unsigned WORDS  = ENTRIES / LANES,
   localparam int unsigned ADDR_W = $clog2(WORDS),
   localparam int unsigned DATA_W = LANES * LANE_W
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      wr_en,
   input  logic [ADDR_W-1:0]         wr_word,
   input  logic [LANES-1:0]          wr_be,
   input  logic [LANES*QIDX_W-1:0]   wr_lanes,
   input  logic [ADDR_W-1:0]         rd_word,
   output logic [DATA_W-1:0]         rd_data,
   input  logic [IDX_W-1:0]          lk_idx,
   output logic [QIDX_W-1:0]         lk_entry
);

   logic [QIDX_W-1:0] ent [ENTRIES];

   for (genvar e = 0; e < ENTRIES; e++) begin : g_ent
      localparam int unsigned WSEL = e / LANES;
      localparam int unsigned LSEL = e % LANES;
      logic [QIDX_W-1:0] ent_q;
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            ent_q <= '0;
         end else if (wr_en && (wr_word == ADDR_W'(WSEL)) && wr_be[LSEL]) begin
            ent_q <= wr_lanes[LSEL*QIDX_W +: QIDX_W];
         end
      end
      assign ent[e] = ent_q;
   end

   always_comb begin
      rd_data = '0;
      for (int l = 0; l < LANES; l++) begin
         rd_data[l*LANE_W +: QIDX_W] = ent[int'(rd_word) * LANES + l];
      end
   end

   assign lk_entry = ent[lk_idx];

endmodule

// File: rtl/rssq_fill.sv
module rssq_fill
   import rssq_pkg::*;
#(
   parameter int unsigned ENTRIES = 128,
   parameter int unsigned QIDX_W  = 3,
   localparam int unsigned WORDS  = ENTRIES / LANES,
   localparam int unsigned ADDR_W = $clog2(WORDS),
   localparam int unsigned QCNT_W = QIDX_W + 1,
   localparam int unsigned MAXQ   = 1 << QIDX_W
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      start,
   input  logic                      allow,
   input  logic [QCNT_W-1:0]         qcount,
   output logic                      busy,
   output logic                      wr_en,
   output logic [ADDR_W-1:0]         wr_word,
   output logic [LANES*QIDX_W-1:0]   wr_lanes
);

   logic [ADDR_W-1:0] word_q;
   logic [QCNT_W-1:0] qlim_q;
   logic [QCNT_W-1:0] base_q;
   logic [QCNT_W-1:0] qsel;
   logic [QCNT_W-1:0] lane_v [LANES];
   logic [QCNT_W-1:0] next_base;

   function automatic logic [QCNT_W-1:0] step(input logic [QCNT_W-1:0] cur,
                                              input logic [QCNT_W-1:0] lim);
      logic [QCNT_W-1:0] n;
      n = cur + 1'b1;
      return (n >= lim) ? '0 : n;
   endfunction

   // zero maps to one queue, oversize counts saturate at the widest index
   always_comb begin
      if (qcount == '0)               qsel = QCNT_W'(1);
      else if (qcount > QCNT_W'(MAXQ)) qsel = QCNT_W'(MAXQ);
      else                            qsel = qcount;
   end

   always_comb begin
      lane_v[0] = base_q;
      for (int k = 1; k < LANES; k++) begin
         lane_v[k] = step(lane_v[k-1], qlim_q);
      end
      next_base = step(lane_v[LANES-1], qlim_q);
      for (int k = 0; k < LANES; k++) begin
         wr_lanes[k*QIDX_W +: QIDX_W] = lane_v[k][QIDX_W-1:0];
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         busy   <= 1'b0;
         word_q <= '0;
         qlim_q <= QCNT_W'(1);
         base_q <= '0;
      end else if (busy) begin
         base_q <= next_base;
         word_q <= word_q + 1'b1;
         if (word_q == ADDR_W'(WORDS - 1)) busy <= 1'b0;
      end else if (start && allow) begin
         busy   <= 1'b1;
         word_q <= '0;
         base_q <= '0;
         qlim_q <= qsel;
      end
   end

   assign wr_en   = busy;
   assign wr_word = word_q;

endmodule

// File: rtl/rssq_lookup.sv
module rssq_lookup #(
   parameter int unsigned HASH_W = 32,
   parameter int unsigned IDX_W  = 7,
   parameter int unsigned QIDX_W = 3
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               hv,
   input  logic [HASH_W-1:0]  hash,
   input  logic               blank,
   input  logic [QIDX_W-1:0]  entry,
   output logic [IDX_W-1:0]   idx,
   output logic               qv,
   output logic [QIDX_W-1:0]  qi
);

   assign idx = hash[IDX_W-1:0];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         qv <= 1'b0;
         qi <= '0;
      end else begin
         qv <= hv;
         if (hv) qi <= blank ? '0 : entry;
      end
   end

endmodule

// File: rtl/rss_queue_map.sv
module rss_queue_map
   import rssq_pkg::*;
#(
   parameter int unsigned ENTRIES = 128,
   parameter int unsigned QIDX_W  = 3,
   parameter int unsigned HASH_W  = 32,
   localparam int unsigned IDX_W  = $clog2(ENTRIES),
   localparam int unsigned WORDS  = ENTRIES / LANES,
   localparam int unsigned ADDR_W = $clog2(WORDS),
   localparam int unsigned DATA_W = LANES * LANE_W,
   localparam int unsigned QCNT_W = QIDX_W + 1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               stop_clr,
   input  logic               fill_start,
   input  logic [QCNT_W-1:0]  fill_qcount,
   output logic               fill_busy,
   output logic               sw_written,
   input  logic               reg_we,
   input  logic [ADDR_W-1:0]  reg_addr,
   input  logic [LANES-1:0]   reg_be,
   input  logic [DATA_W-1:0]  reg_wdata,
   output logic [DATA_W-1:0]  reg_rdata,
   input  logic               hash_valid,
   input  logic [HASH_W-1:0]  hash,
   output logic               q_valid,
   output logic [QIDX_W-1:0]  q_index
);

   if ((1 << IDX_W) != ENTRIES || ENTRIES % LANES != 0) begin : g_bad_entries
      $error("ENTRIES must be a power of two and a multiple of the lane count");
   end
   if (QIDX_W > LANE_W || QIDX_W == 0) begin : g_bad_qidx
      $error("QIDX_W must fit a byte lane");
   end
   if (HASH_W < IDX_W) begin : g_bad_hash
      $error("HASH_W too narrow for the table index");
   end

   logic                    f_we;
   logic [ADDR_W-1:0]       f_word;
   logic [LANES*QIDX_W-1:0] f_lanes;
   logic [LANES*QIDX_W-1:0] s_lanes;
   logic                    s_we;
   wsrc_e                   src;
   logic                    t_we;
   logic [ADDR_W-1:0]       t_word;
   logic [LANES-1:0]        t_be;
   logic [LANES*QIDX_W-1:0] t_lanes;
   logic [IDX_W-1:0]        lk_idx;
   logic [QIDX_W-1:0]       lk_entry;
   logic                    owned_q;

   for (genvar l = 0; l < LANES; l++) begin : g_sw_lane
      assign s_lanes[l*QIDX_W +: QIDX_W] = reg_wdata[l*LANE_W +: QIDX_W];
   end

   // software writes only land while the fill engine is idle
   assign s_we   = reg_we && !fill_busy && (reg_be != '0);
   assign src    = fill_busy ? WSRC_FILL : WSRC_SW;
   assign t_we   = (src == WSRC_FILL) ? f_we : s_we;
   assign t_word = (src == WSRC_FILL) ? f_word : reg_addr;
   assign t_be   = (src == WSRC_FILL) ? '1 : reg_be;
   assign t_lanes = (src == WSRC_FILL) ? f_lanes : s_lanes;

   always_ff @(posedge clk) begin
      if (!rst_n)        owned_q <= 1'b0;
      else if (stop_clr) owned_q <= 1'b0;
      else if (s_we)     owned_q <= 1'b1;
   end
   assign sw_written = owned_q;

   rssq_fill #(
      .ENTRIES (ENTRIES),
      .QIDX_W  (QIDX_W)
   ) i_fill (
      .clk      (clk),
      .rst_n    (rst_n),
      .start    (fill_start),
      .allow    (!owned_q),
      .qcount   (fill_qcount),
      .busy     (fill_busy),
      .wr_en    (f_we),
      .wr_word  (f_word),
      .wr_lanes (f_lanes)
   );

   rssq_table #(
      .ENTRIES (ENTRIES),
      .QIDX_W  (QIDX_W)
   ) i_table (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_en    (t_we),
      .wr_word  (t_word),
      .wr_be    (t_be),
      .wr_lanes (t_lanes),
      .rd_word  (reg_addr),
      .rd_data  (reg_rdata),
      .lk_idx   (lk_idx),
      .lk_entry (lk_entry)
   );

   rssq_lookup #(
      .HASH_W (HASH_W),
      .IDX_W  (IDX_W),
      .QIDX_W (QIDX_W)
   ) i_lookup (
      .clk   (clk),
      .rst_n (rst_n),
      .hv    (hash_valid),
      .hash  (hash),
      .blank (fill_busy),
      .entry (lk_entry),
      .idx   (lk_idx),
      .qv    (q_valid),
      .qi    (q_index)
   );

endmodule

// File: rtl/rssq_checker.sv
module rssq_checker
   import rssq_pkg::*;
#(
   parameter int unsigned ENTRIES = 128,
   parameter int unsigned QIDX_W  = 3,
   parameter int unsigned HASH_W  = 32,
   localparam int unsigned WORDS  = ENTRIES / LANES,
   localparam int unsigned ADDR_W = $clog2(WORDS),
   localparam int unsigned DATA_W = LANES * LANE_W,
   localparam int unsigned QCNT_W = QIDX_W + 1
) (
   input logic               clk,
   input logic               rst_n,
   input logic               stop_clr,
   input logic               fill_start,
   input logic [QCNT_W-1:0]  fill_qcount,
   input logic               fill_busy,
   input logic               sw_written,
   input logic               reg_we,
   input logic [ADDR_W-1:0]  reg_addr,
   input logic [LANES-1:0]   reg_be,
   input logic [DATA_W-1:0]  reg_rdata,
   input logic               hash_valid,
   input logic               q_valid,
   input logic [QIDX_W-1:0]  q_index
);

   logic [DATA_W-1:0] pad_mask;
   always_comb begin
      pad_mask = '1;
      for (int l = 0; l < LANES; l++) pad_mask[l*LANE_W +: QIDX_W] = '0;
   end

   // consecutive busy cycles seen so far
   logic [ADDR_W:0] run_q;
   always_ff @(posedge clk) begin
      if (!rst_n)         run_q <= '0;
      else if (fill_busy) run_q <= run_q + 1'b1;
      else                run_q <= '0;
   end

   p_valid_r1: assert property (@(posedge clk) disable iff (!rst_n)
      hash_valid |=> q_valid);
   p_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
      !hash_valid |=> !q_valid);
   p_pad_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_rdata & pad_mask) == '0);
   p_start_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (fill_start && !sw_written && !fill_busy) |=> fill_busy);
   p_len_r5: assert property (@(posedge clk) disable iff (!rst_n)
      fill_busy |-> (run_q < (ADDR_W+1)'(WORDS)));
   p_end_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (run_q == (ADDR_W+1)'(WORDS - 1) && fill_busy) |=> !fill_busy);
   p_blank_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (hash_valid && fill_busy) |=> (q_index == '0));
   p_skip_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (fill_start && sw_written && !fill_busy) |=> !fill_busy);
   p_set_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_we && reg_be != '0 && !fill_busy && !stop_clr) |=> sw_written);
   p_clr_r9: assert property (@(posedge clk) disable iff (!rst_n)
      stop_clr |=> !sw_written);
   p_drop_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_we && fill_busy && !stop_clr) |=> $stable(sw_written));

endmodule

bind rss_queue_map rssq_checker #(
   .ENTRIES (ENTRIES),
   .QIDX_W  (QIDX_W),
   .HASH_W  (HASH_W)
) u_rssq_checker (.*);

// File: tb/test_rss_queue_map.sv
`timescale 1ns/1ps
module test_rss_queue_map;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        stop_clr = 1'b0;
   logic        fill_start = 1'b0;
   logic [3:0]  fill_qcount = '0;
   logic        fill_busy;
   logic        sw_written;
   logic        reg_we = 1'b0;
   logic [4:0]  reg_addr = '0;
   logic [3:0]  reg_be = '0;
   logic [31:0] reg_wdata = '0;
   logic [31:0] reg_rdata;
   logic        hash_valid = 1'b0;
   logic [31:0] hash = '0;
   logic        q_valid;
   logic [2:0]  q_index;

   int checks = 0;
   int errors = 0;
   logic [2:0] model [128];
   int    exp_q [$];
   string tag_q [$];

   always #4 clk = ~clk;

   rss_queue_map i_rss_queue_map (.*);

   task automatic check(input bit ok, input string tag, input longint act, input longint exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
      end
   endtask

   function automatic logic [31:0] pack(input int w);
      logic [31:0] r = '0;
      for (int l = 0; l < 4; l++) r[l*8 +: 3] = model[w*4 + l];
      return r;
   endfunction

   task automatic rd_chk(input int w, input string tag);
      @(negedge clk);
      reg_addr = 5'(w);
      #1;
      check(reg_rdata == pack(w), tag, reg_rdata, pack(w));
   endtask

   task automatic rd_all(input string tag);
      for (int w = 0; w < 32; w++) rd_chk(w, tag);
   endtask

   task automatic wr(input int w, input logic [3:0] be, input logic [31:0] d, input bit apply);
      @(negedge clk);
      reg_we = 1'b1; reg_addr = 5'(w); reg_be = be; reg_wdata = d;
      @(negedge clk);
      reg_we = 1'b0; reg_be = '0;
      if (apply)
         for (int l = 0; l < 4; l++) if (be[l]) model[w*4 + l] = d[l*8 +: 3];
   endtask

   // driver: present one lookup, push its expected queue
   task automatic look(input logic [31:0] h, input int exp, input string tag);
      @(negedge clk);
      hash_valid = 1'b1; hash = h;
      exp_q.push_back(exp); tag_q.push_back(tag);
      @(negedge clk);
      hash_valid = 1'b0;
   endtask

   // monitor: compare every result as it appears
   always @(negedge clk) begin
      if (rst_n && q_valid) begin
         if (exp_q.size() == 0) begin
            check(0, "R1 unexpected q_valid", 1, 0);
         end else begin
            automatic int    e = exp_q.pop_front();
            automatic string t = tag_q.pop_front();
            check(q_index == 3'(e), t, q_index, e);
         end
      end
   end

   function automatic void model_fill(input int q);
      int qe = (q == 0) ? 1 : ((q > 8) ? 8 : q);
      for (int i = 0; i < 128; i++) model[i] = 3'(i % qe);
   endfunction

   task automatic fill(input int q, input string tag);
      int n = 0;
      @(negedge clk);
      fill_start = 1'b1; fill_qcount = 4'(q);
      @(negedge clk);
      fill_start = 1'b0;
      while (fill_busy && n < 100) begin n++; @(negedge clk); end
      check(n == 32, tag, n, 32);
      model_fill(q);
   endtask

   task automatic sweep(input string tag);
      for (int k = 0; k < 16; k++) begin
         automatic int idx = (k * 37 + 5) % 128;
         automatic logic [31:0] h = {25'(k * 32'h9E37_79B1 + 1), 7'(idx)};
         look(h, model[idx], tag);
      end
   endtask

   initial begin
      #(8 * 150000);
      check(0, "watchdog", 0, 1);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      for (int i = 0; i < 128; i++) model[i] = '0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      #1;
      // R9 reset state
      check(fill_busy == 0, "R9 busy after reset", fill_busy, 0);
      check(q_valid == 0, "R9 q_valid after reset", q_valid, 0);
      check(sw_written == 0, "R9 written after reset", sw_written, 0);
      rd_all("R9 table zero after reset");
      look(32'hFFFF_FF80, 0, "R1 lookup after reset");

      // R5 R2 fill over 5 queues, then lookups R1
      fill(5, "R5 busy length q=5");
      rd_all("R5 R2 fill q=5 contents");
      check(sw_written == 0, "R5 fill leaves written clear", sw_written, 0);
      sweep("R1 lookup after q=5 fill");
      look(32'hDEAD_BE7F, model[127], "R1 top entry");
      look(32'h1234_5600, model[0], "R1 bottom entry");

      // R7 lookups and R10 dropped writes during a fill over 3 queues
      @(negedge clk);
      fill_start = 1'b1; fill_qcount = 4'd3;
      @(negedge clk);
      fill_start = 1'b0;
      check(fill_busy == 1, "R5 busy raised", fill_busy, 1);
      look(32'h0000_0001, 0, "R7 lookup during fill");
      look(32'h0000_0042, 0, "R7 lookup during fill");
      wr(31, 4'hF, 32'h0707_0707, 1'b0);
      look(32'h0000_007E, 0, "R7 lookup during fill");
      while (fill_busy) @(negedge clk);
      model_fill(3);
      check(sw_written == 0, "R10 written unchanged by dropped write", sw_written, 0);
      rd_chk(31, "R10 word 31 holds fill values");
      rd_all("R5 fill q=3 contents");

      // R3 masked write and R8 flag set
      wr(5, 4'b0101, 32'hAA0B_0C0D, 1'b1);
      rd_chk(5, "R3 masked write lanes 0 and 2");
      check(sw_written == 1, "R8 written set", sw_written, 1);
      wr(9, 4'b1000, 32'hFF00_0000, 1'b1);
      rd_chk(9, "R3 masked write lane 3 low bits");
      wr(10, 4'b0000, 32'h0505_0505, 1'b0);
      rd_chk(10, "R3 empty byte enable");

      // R4 write and lookup of entry 20 in the same cycle
      @(negedge clk);
      reg_we = 1'b1; reg_addr = 5'd5; reg_be = 4'b0001; reg_wdata = 32'h0000_0002;
      hash_valid = 1'b1; hash = 32'h5555_5514;
      exp_q.push_back(model[20]); tag_q.push_back("R4 old value on collision");
      @(negedge clk);
      reg_we = 1'b0; reg_be = '0; hash_valid = 1'b0;
      model[20] = 3'd2;
      look(32'h0000_0014, 2, "R4 new value afterwards");

      // R8 fill refused while owned
      @(negedge clk);
      fill_start = 1'b1; fill_qcount = 4'd7;
      @(negedge clk);
      fill_start = 1'b0;
      check(fill_busy == 0, "R8 fill refused", fill_busy, 0);
      repeat (3) @(negedge clk);
      rd_all("R8 table unchanged after refused fill");

      // R9 stop clears flag, table kept
      @(negedge clk);
      stop_clr = 1'b1;
      @(negedge clk);
      stop_clr = 1'b0;
      check(sw_written == 0, "R9 stop clears written", sw_written, 0);
      rd_chk(5, "R9 stop keeps table");

      // R6 clamps
      fill(0, "R6 busy length q=0");
      rd_all("R6 q=0 fills zeros");
      fill(12, "R6 busy length q=12");
      rd_all("R6 q=12 clamps to 8");
      sweep("R1 lookup after q=12 fill");

      // R9 reset clears the table and flag
      wr(2, 4'hF, 32'h0102_0304, 1'b1);
      @(negedge clk);
      rst_n = 1'b0;
      @(negedge clk);
      rst_n = 1'b1;
      for (int i = 0; i < 128; i++) model[i] = '0;
      #1;
      check(sw_written == 0, "R9 reset clears written", sw_written, 0);
      rd_all("R9 reset clears table");

      repeat (4) @(negedge clk);
      check(exp_q.size() == 0, "R1 all lookups answered", exp_q.size(), 0);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule